// File: doc/BRIEF.md
# Serial Loss-of-Signal Detector

This block watches a serial data line that is sampled once per bit period. A one-cycle strobe marks each bit sample. When the line stays frozen at one level for too many bit periods, the block raises an active-high loss-of-signal flag. The frozen level can be all zeros or all ones. The flag drops again only after the line has been free of such defects for a long, separate interval.

Both intervals are parameters counted in bit periods. To use the block at a given line rate, convert the two time limits into bit counts. The set count must lie between 2.3 µs and 100 µs worth of bits. The clear count must lie between 125 µs and 250 µs worth of bits.

The serial input is a plain sampled bit, not a stream. The block accepts every strobed sample, has no way to refuse one, and so applies no back-pressure. Cycles without the strobe are ignored.

Top module: `sig_loss_detector`

## Requirements
- R1: After reset `los` is 0. The run and clear counts start from zero, and no previous bit is held.
- R2: While `los` is 0, a run of `SET_BITS-1` or fewer identical samples never raises `los`.
- R3: The `SET_BITS`-th consecutive identical sample raises `los` on the same clock edge that takes that sample.
- R4: The stuck level can be 0 or 1. A frozen line of either polarity is detected the same way.
- R5: A sample that differs from the previous sampled bit ends the current run. A new run of length one starts with that sample.
- R6: Cycles with `sample_en` at 0 change nothing, whatever `serial_bit` does. They neither extend nor break a run, and they do not advance the clear count.
- R7: While `los` is 1, each sample that does not complete a `SET_BITS` run counts as defect-free. `los` falls on the edge that takes the `CLR_BITS`-th such sample, and not before.
- R8: While `los` is 1, any run that reaches `SET_BITS` restarts the defect-free count from zero.
- R9: The run counter saturates and does not wrap. A frozen line of any length keeps `los` at 1.
- R10: The first sample after reset starts a run of length one. `SET_BITS` identical samples from reset therefore raise `los`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | One-cycle strobe marking a bit sample |
| serial_bit | input | 1 | Sampled serial data bit, valid when `sample_en` is 1 |
| los | output | 1 | Loss-of-signal flag, active high |

## Verification
The assertions assume that `sample_en` and `serial_bit` are known 0/1 values at every clock edge after reset. They also assume that reset is held from time zero until the clock runs. The stimulus drives both inputs only on falling clock edges and uses only 0 and 1. It holds `rst_n` low from the first instant.

The idle cycles inserted between samples deliberately toggle `serial_bit`. This shows that values seen outside the strobe never count as line activity. Randomised run lengths cluster around `SET_BITS` and stay below a few multiples of it. Directed runs cover the exact boundaries of both the set count and the clear count.

// File: rtl/sld_pkg.sv
`timescale 1ns/1ps
package sld_pkg;
  typedef enum logic {
    SLD_LIVE = 1'b0,
    SLD_LOST = 1'b1
  } sld_state_e;
endpackage

// File: rtl/sld_sat_count.sv
`timescale 1ns/1ps
// Saturating up-counter with a restart value; exposes its next value.
module sld_sat_count #(
  parameter int unsigned MAX   = 16,
  parameter int unsigned START = 0,
  localparam int unsigned W    = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_d
);
  localparam logic [W-1:0] TOP = W'(MAX);
  localparam logic [W-1:0] ST  = W'(START);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (restart)                    count_d = ST;
    else if (step && count_q != TOP) count_d = count_q + ONE;
    else                            count_d = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // R9: once full, further steps keep the counter at its ceiling
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && count_q == TOP) |=> (count_q == TOP));
endmodule

// File: rtl/sld_flip_detect.sv
`timescale 1ns/1ps
// Remembers the last sampled bit and flags a sample that differs from it.
module sld_flip_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic serial_bit,
  output logic seen_o,
  output logic flip_o
);
  logic prev_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (sample_en) begin
      prev_q <= serial_bit;
      seen_q <= 1'b1;
    end
  end

  assign seen_o = seen_q;
  assign flip_o = seen_q && (serial_bit != prev_q);

  // R6: idle cycles leave the remembered bit untouched
  assert_idle_keeps_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(prev_q) && $stable(seen_q)));
  // R10: after any sample, a previous bit is held
  assert_first_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> seen_q);
endmodule

// File: rtl/sld_los_state.sv
`timescale 1ns/1ps
// Flag state plus defect-free counter.
module sld_los_state
  import sld_pkg::*;
#(
  parameter int unsigned CLR_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic hit,
  output logic los_o
);
  localparam int unsigned CW = $clog2(CLR_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(CLR_BITS - 1);

  sld_state_e state_q, state_d;
  logic [CW-1:0] clr_q, clr_d;
  logic lost, done, clr_restart;

  assign lost        = (state_q == SLD_LOST);
  assign done        = lost && sample_en && !hit && (clr_q == LAST);
  assign clr_restart = !lost || hit || done;

  sld_sat_count #(.MAX(CLR_BITS), .START(0)) u_clr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (clr_restart),
    .step    (sample_en),
    .count_q (clr_q),
    .count_d (clr_d)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLD_LIVE: if (hit)  state_d = SLD_LOST;
      SLD_LOST: if (done) state_d = SLD_LIVE;
      default:            state_d = SLD_LIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLD_LIVE;
    else        state_q <= state_d;
  end

  assign los_o = lost;

  // R3: a completed run while live raises the flag on the next state
  assert_set_on_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lost && hit) |=> los_o);
  // R2: no completed run, no rise
  assert_no_early_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lost && !hit) |=> !los_o);
  // R6: idle cycles never move the flag
  assert_idle_holds_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(los_o));
  // R7: the flag only falls after the last defect-free sample
  assert_clear_after_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_o) |-> ($past(clr_q) == LAST && $past(sample_en)));
  // R8: a new run while lost restarts the count and keeps the flag
  assert_rerun_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && hit) |=> (los_o && clr_q == '0));
  // clear count is unused while live (supports R1/R7)
  assert_idle_count_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lost |=> (!los_o || clr_q == '0));
endmodule

// File: rtl/sig_loss_detector.sv
`timescale 1ns/1ps
// Loss-of-signal detector for a bit-strobed serial line.
module sig_loss_detector #(
  parameter int unsigned SET_BITS = 4096,
  parameter int unsigned CLR_BITS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic serial_bit,
  output logic los
);
  localparam int unsigned RW = $clog2(SET_BITS + 1);
  localparam logic [RW-1:0] SET_V = RW'(SET_BITS);
  localparam logic [RW-1:0] ONE_V = RW'(1);

  logic seen, flip, hit, run_restart;
  logic [RW-1:0] run_q, run_d;

  sld_flip_detect u_flip (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .serial_bit (serial_bit),
    .seen_o     (seen),
    .flip_o     (flip)
  );

  assign run_restart = sample_en && (!seen || flip);

  sld_sat_count #(.MAX(SET_BITS), .START(1)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (run_restart),
    .step    (sample_en),
    .count_q (run_q),
    .count_d (run_d)
  );

  assign hit = sample_en && (run_d == SET_V);

  sld_los_state #(.CLR_BITS(CLR_BITS)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .hit       (hit),
    .los_o     (los)
  );

  // R5: a differing sample starts a fresh run of length one
  assert_flip_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && flip) |=> (run_q == ONE_V));
  // R4: an equal sample lengthens the run regardless of level
  assert_same_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && seen && !flip && run_q != SET_V) |=> (run_q == $past(run_q) + ONE_V));
  // R9: a saturated run keeps the flag raised
  assert_full_run_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && seen && !flip && run_q == SET_V) |=> los);
endmodule

// File: tb/sim_sig_loss_detector.sv
`timescale 1ns/1ps
module sim_sig_loss_detector;
  localparam int SET = 16;
  localparam int CLR = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic serial_bit = 1'b0;
  logic los;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  bit m_have = 0;
  bit m_prev = 0;
  int m_run = 0;
  bit m_los = 0;
  int m_clr = 0;

  sig_loss_detector #(.SET_BITS(SET), .CLR_BITS(CLR)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .serial_bit(serial_bit), .los(los)
  );

  always #2.5 clk = ~clk;

  function automatic int next_run(bit have, bit prev, bit b, int run);
    if (!have || b != prev) return 1;
    return (run >= SET) ? SET : run + 1;
  endfunction

  function automatic bit run_complete(int run);
    return run == SET;
  endfunction

  task automatic check(input bit exp, input string tag);
    total++;
    if (los !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, los, exp, $time);
    end
  endtask

  task automatic samp(input bit en, input bit b, input string tag);
    int r;
    @(negedge clk);
    sample_en = en;
    serial_bit = b;
    @(posedge clk);
    if (en) begin
      r = next_run(m_have, m_prev, b, m_run);
      m_have = 1; m_prev = b; m_run = r;
      if (!m_los) begin
        if (run_complete(r)) m_los = 1;
        m_clr = 0;
      end else if (run_complete(r)) begin
        m_clr = 0;
      end else begin
        m_clr++;
        if (m_clr == CLR) begin m_los = 0; m_clr = 0; end
      end
    end
    #1;
    check(m_los, tag);
  endtask

  task automatic run_of(input bit b, input int n, input string tag);
    for (int i = 0; i < n; i++) samp(1'b1, b, tag);
  endtask

  task automatic toggles(input int n, input string tag);
    for (int i = 0; i < n; i++) samp(1'b1, ~m_prev, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    samp(1'b0, 1'b1, "R1 idle after reset");

    // R10/R2/R3: zeros from reset
    run_of(1'b0, SET - 1, "R2 short zero run");
    check(1'b0, "R2 after SET-1 zeros");
    run_of(1'b0, 1, "R3 R10 SET-th zero");
    check(1'b1, "R3 set on SET-th zero");

    // R9: very long frozen line
    run_of(1'b0, 5 * SET, "R9 saturated run");
    check(1'b1, "R9 still lost");

    // R7: clear boundary
    toggles(CLR - 1, "R7 before clear");
    check(1'b1, "R7 one short of clear");
    toggles(1, "R7 clear sample");
    check(1'b0, "R7 cleared");

    // R4: ones polarity
    run_of(~m_prev, SET - 1, "R4 R2 ones short");
    check(1'b0, "R4 ones SET-1");
    run_of(m_prev, 1, "R4 ones SET-th");
    check(1'b1, "R4 ones set");

    // R8: re-run during clearing
    toggles(CLR / 2, "R8 partial clear");
    run_of(m_prev, SET, "R8 new run");
    check(1'b1, "R8 held");
    toggles(CLR - 1, "R8 restarted count");
    check(1'b1, "R8 not yet cleared");
    toggles(1, "R8 final");
    check(1'b0, "R8 cleared after full count");

    // R5: runs broken just short of threshold
    run_of(1'b0, SET - 1, "R5 zeros");
    run_of(1'b1, SET - 1, "R5 ones");
    run_of(1'b0, SET - 1, "R5 zeros again");
    check(1'b0, "R5 no set on broken runs");

    // R6: idle cycles with toggling data inside a run
    toggles(1, "R6 prep");
    for (int i = 0; i < SET - 1; i++) begin
      samp(1'b1, 1'b1 ^ m_prev ^ 1'b1, "R6 run");
      samp(1'b0, ~m_prev, "R6 idle toggle");
    end
    check(1'b1, "R6 run not broken by idle");
    for (int i = 0; i < 10; i++) samp(1'b0, i[0], "R6 idle while lost");
    check(1'b1, "R6 flag held over idle");

    // random runs with idle gaps
    begin
      bit v = 1'b0;
      for (int k = 0; k < 60; k++) begin
        int len;
        case ($urandom % 4)
          0: len = SET - 1;
          1: len = SET;
          2: len = 1 + ($urandom % 4);
          default: len = 1 + ($urandom % (3 * SET));
        endcase
        for (int i = 0; i < len; i++) begin
          if ($urandom % 5 == 0) samp(1'b0, ~v, "R6 random idle");
          samp(1'b1, v, "R3,R7 random");
        end
        v = ~v;
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog R1..all actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule